// File: doc/BRIEF.md
# Per-Processor Software Interrupt Pending Register

This block sits beside one processor and collects every interrupt request meant for it. It keeps a 32-bit pending word. The upper fifteen bits are software interrupts, which software raises and drops through two write-only command words. Bit 14 follows a private timer line. Bit 15 latches a broadcast level-15 request that all processors see. The lower bits show the hard-interrupt levels that the system router maps to this processor whenever it is the current target.

The block merges the routed hard levels, the software requests and the gated timer and broadcast requests into a 15-line level vector, numbered 1 to 15. There is no level 0. The vector is registered, so it follows any write or input change by one clock. Software requests ignore every disable. The timer and broadcast requests answer only to the router's global disable.

Top module: `pcpu_intc`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pending word becomes 0 and `irq_lvl` becomes 0 after that edge.
- R2: An aligned read at byte offset 0x0 returns the pending word. Bits 0 and 16 of that word always read 0. Reads at 0x4, 0x8 and 0xC, and any read whose two low address bits are not 00, return 0.
- R3: An aligned write to 0x8 sets the pending bits that are 1 in the data, only within bits 31..17. All other data bits have no effect.
- R4: An aligned write to 0x4 clears the pending bits that are 1 in the data, only within bits 31..17 and bit 15. Bit 14 and the display bits 13..1 are never cleared by it.
- R5: Writes to 0x0 or 0xC, and any write whose two low address bits are not 00, change no state.
- R6: Pending bit 16+L (L = 1..15) requests level L on `irq_lvl`, whatever the state of `global_dis`.
- R7: Pending bit 14 equals the level of `timer_in` sampled at the previous clock edge.
- R8: Pending bit 15 is set on a rising `bcast_in` and cleared on a falling `bcast_in` or by R4. If a rising edge and a software clear happen in the same cycle, the set wins.
- R9: Pending bits 15 and 14 request levels 15 and 14 only while `global_dis` was 0 at the previous edge.
- R10: While `is_target` is 1, each `hard_disp` level L shows as an additional 1 in pending bit L (bits 15..1), whether or not that source is enabled. While `is_target` is 0, no display bits are shown.
- R11: `irq_lvl` is, one clock after the inputs, the OR of `hard_route`, the soft requests of R6 and the gated requests of R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register interface |
| reg_addr | input | 4 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| timer_in | input | 1 | Per-processor timer request level |
| bcast_in | input | 1 | Broadcast level-15 request level |
| is_target | input | 1 | This processor is the router's current hard-interrupt target |
| global_dis | input | 1 | Router's global disable |
| hard_route | input | 15 | Enabled hard levels routed to this processor (bit L = level L) |
| hard_disp | input | 15 | Mapped levels of all pending hard sources, for display (bit L = level L) |
| irq_lvl | output | 15 | Level request vector to the processor (bit L = level L) |

## Verification
A corrupted software bit shows up in two places on the next clock. It appears as a wrong bit in a read of the pending word, and as a wrong line on `irq_lvl`. A broadcast latch that misses an edge is visible only as a bit-15 error, and it persists until the next edge of `bcast_in` or the next software clear, so runs must hold `bcast_in` both high and low across clears. Display and gating errors depend only on inputs from the previous cycle, so they show one clock after the input pattern that provokes them. They disappear one clock after it ends, which means every cycle must be compared.

// File: rtl/pcpu_intc_pkg.sv
// Package: shared constants for the per-processor interrupt pending block.
// Assumes 32-bit data words and byte addressing with 4-byte alignment.
package pcpu_intc_pkg;
    // word index of each register (byte address bits [3:2])
    localparam int unsigned IDX_PEND = 0;
    localparam int unsigned IDX_CLR  = 1;
    localparam int unsigned IDX_SET  = 2;

    // decoded command of one register access
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_CLR  = 2'd1,
        CMD_SET  = 2'd2
    } wr_cmd_e;
endpackage

// File: rtl/pcpu_regif.sv
// Module: address decoder and read multiplexer for the pending register.
// Assumes aligned word accesses; any access with nonzero low address bits
// is treated as a miss (writes dropped, reads return zero).
module pcpu_regif
    import pcpu_intc_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] pend_word,
    output wr_cmd_e           wr_cmd,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic             aligned;
    logic [IDX_W-1:0] word_idx;

    assign aligned  = (reg_addr[1:0] == 2'b00);
    assign word_idx = reg_addr[ADDR_W-1:2];

    // decode the write into a clear or set command
    always_comb begin
        wr_cmd = CMD_NONE;
        if (reg_wr && aligned) begin
            if (word_idx == IDX_W'(IDX_CLR))      wr_cmd = CMD_CLR;
            else if (word_idx == IDX_W'(IDX_SET)) wr_cmd = CMD_SET;
        end
    end

    // only the pending word is readable; everything else reads zero
    always_comb begin
        reg_rdata = '0;
        if (aligned && word_idx == IDX_W'(IDX_PEND)) reg_rdata = pend_word;
    end
endmodule

// File: rtl/pcpu_pend.sv
// Module: pending state of one processor: software bits, broadcast latch,
// timer mirror and the target display bits, plus the assembled read word.
// Assumes level inputs are synchronous to clk. Exposes next-state values
// so the request register can update on the same edge.
module pcpu_pend
    import pcpu_intc_pkg::*;
#(
    parameter int unsigned NUM_LVL = 15,
    parameter int unsigned DATA_W  = 2 * (NUM_LVL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_cmd_e           wr_cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              timer_in,
    input  logic              bcast_in,
    input  logic              is_target,
    input  logic [NUM_LVL:1]  hard_disp,
    output logic [NUM_LVL:1]  soft_q,
    output logic              b15_q,
    output logic              tmr_q,
    output logic [NUM_LVL:1]  disp_q,
    output logic              bc_prev_q,
    output logic [NUM_LVL:1]  soft_d,
    output logic              b15_d,
    output logic              tmr_d,
    output logic [DATA_W-1:0] pend_word
);
    localparam int unsigned SOFT_BASE = NUM_LVL + 1;
    localparam int unsigned LVL_BC    = NUM_LVL;
    localparam int unsigned LVL_TMR   = NUM_LVL - 1;

    logic [NUM_LVL:1] wr_bits;
    logic [NUM_LVL:1] disp_d;
    logic             bc_rise, bc_fall, sw_clr15;

    assign wr_bits  = wdata[DATA_W-1:SOFT_BASE+1];
    assign bc_rise  = bcast_in && !bc_prev_q;
    assign bc_fall  = !bcast_in && bc_prev_q;
    assign sw_clr15 = (wr_cmd == CMD_CLR) && wdata[LVL_BC];

    // next software bits: clear first, then set, so set dominates
    always_comb begin
        soft_d = soft_q;
        if (wr_cmd == CMD_CLR) soft_d = soft_d & ~wr_bits;
        if (wr_cmd == CMD_SET) soft_d = soft_d | wr_bits;
    end

    // next broadcast latch: a rising edge beats any clear
    always_comb begin
        b15_d = b15_q;
        if (bc_rise)                 b15_d = 1'b1;
        else if (bc_fall || sw_clr15) b15_d = 1'b0;
    end

    assign tmr_d  = timer_in;
    assign disp_d = is_target ? hard_disp : '0;

    // state register for all pending sources
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q    <= '0;
            b15_q     <= 1'b0;
            tmr_q     <= 1'b0;
            disp_q    <= '0;
            bc_prev_q <= 1'b0;
        end else begin
            soft_q    <= soft_d;
            b15_q     <= b15_d;
            tmr_q     <= tmr_d;
            disp_q    <= disp_d;
            bc_prev_q <= bcast_in;
        end
    end

    // assemble the readable word, one generate slice per level
    assign pend_word[0]         = 1'b0;
    assign pend_word[SOFT_BASE] = 1'b0;
    for (genvar lv = 1; lv <= NUM_LVL; lv++) begin : g_word
        if (lv == LVL_BC) begin : g_bc
            assign pend_word[lv] = disp_q[lv] | b15_q;
        end else if (lv == LVL_TMR) begin : g_tmr
            assign pend_word[lv] = disp_q[lv] | tmr_q;
        end else begin : g_hw
            assign pend_word[lv] = disp_q[lv];
        end
        assign pend_word[SOFT_BASE+lv] = soft_q[lv];
    end
endmodule

// File: rtl/pcpu_merge.sv
// Module: registered merge of all request sources into the level vector.
// Assumes hard_route is already gated by the router; only the timer and
// broadcast requests are gated here, by global_dis.
module pcpu_merge #(
    parameter int unsigned NUM_LVL = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_LVL:1] soft_d,
    input  logic             b15_d,
    input  logic             tmr_d,
    input  logic [NUM_LVL:1] hard_route,
    input  logic             global_dis,
    output logic [NUM_LVL:1] irq_lvl
);
    localparam int unsigned LVL_BC  = NUM_LVL;
    localparam int unsigned LVL_TMR = NUM_LVL - 1;

    logic [NUM_LVL:1] irq_d;

    // per-level OR of the three source classes
    for (genvar lv = 1; lv <= NUM_LVL; lv++) begin : g_lvl
        if (lv == LVL_BC) begin : g_bc
            assign irq_d[lv] = hard_route[lv] | soft_d[lv] | (b15_d & ~global_dis);
        end else if (lv == LVL_TMR) begin : g_tmr
            assign irq_d[lv] = hard_route[lv] | soft_d[lv] | (tmr_d & ~global_dis);
        end else begin : g_plain
            assign irq_d[lv] = hard_route[lv] | soft_d[lv];
        end
    end

    // output register for the level vector
    always_ff @(posedge clk) begin
        if (!rst_n) irq_lvl <= '0;
        else        irq_lvl <= irq_d;
    end
endmodule

// File: rtl/pcpu_intc.sv
// Module: per-processor interrupt pending register, top level.
// Ties the register decoder, the pending state and the request merge.
// Assumes one access per cycle and a combinational read path.
module pcpu_intc
    import pcpu_intc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned NUM_LVL = 15,
    parameter int unsigned DATA_W  = 2 * (NUM_LVL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              timer_in,
    input  logic              bcast_in,
    input  logic              is_target,
    input  logic              global_dis,
    input  logic [NUM_LVL:1]  hard_route,
    input  logic [NUM_LVL:1]  hard_disp,
    output logic [NUM_LVL:1]  irq_lvl
);
    wr_cmd_e           wr_cmd;
    logic [DATA_W-1:0] pend_word;
    logic [NUM_LVL:1]  soft_q, soft_d, disp_q;
    logic              b15_q, b15_d, tmr_q, tmr_d, bc_prev_q;

    pcpu_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .pend_word (pend_word),
        .wr_cmd    (wr_cmd),
        .reg_rdata (reg_rdata)
    );

    pcpu_pend #(.NUM_LVL(NUM_LVL), .DATA_W(DATA_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cmd    (wr_cmd),
        .wdata     (reg_wdata),
        .timer_in  (timer_in),
        .bcast_in  (bcast_in),
        .is_target (is_target),
        .hard_disp (hard_disp),
        .soft_q    (soft_q),
        .b15_q     (b15_q),
        .tmr_q     (tmr_q),
        .disp_q    (disp_q),
        .bc_prev_q (bc_prev_q),
        .soft_d    (soft_d),
        .b15_d     (b15_d),
        .tmr_d     (tmr_d),
        .pend_word (pend_word)
    );

    pcpu_merge #(.NUM_LVL(NUM_LVL)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_d     (soft_d),
        .b15_d      (b15_d),
        .tmr_d      (tmr_d),
        .hard_route (hard_route),
        .global_dis (global_dis),
        .irq_lvl    (irq_lvl)
    );
endmodule

// File: rtl/pcpu_intc_chk.sv
// Module: property checker for pcpu_intc, attached by bind below.
// Assumes it sees the top's pending state and level output each clock.
module pcpu_intc_chk #(
    parameter int unsigned NUM_LVL = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             timer_in,
    input logic             bcast_in,
    input logic             is_target,
    input logic             global_dis,
    input logic [NUM_LVL:1] hard_route,
    input logic [NUM_LVL:1] irq_lvl,
    input logic [NUM_LVL:1] soft_q,
    input logic             b15_q,
    input logic             tmr_q,
    input logic [NUM_LVL:1] disp_q,
    input logic             bc_prev_q
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_lvl == '0 && soft_q == '0 && !b15_q));

    p_soft_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_q & ~irq_lvl) == '0);

    p_timer_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (tmr_q == $past(timer_in)));

    p_rise_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_in && !bc_prev_q) |=> b15_q);

    p_bc_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lvl[NUM_LVL] |-> (soft_q[NUM_LVL] || $past(hard_route[NUM_LVL]) || !$past(global_dis)));

    p_tmr_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lvl[NUM_LVL-1] |-> (soft_q[NUM_LVL-1] || $past(hard_route[NUM_LVL-1]) || !$past(global_dis)));

    p_no_display_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !is_target |=> (disp_q == '0));
endmodule

bind pcpu_intc pcpu_intc_chk #(.NUM_LVL(NUM_LVL)) u_chk (.*);

// File: tb/test_pcpu_intc.sv
// Bench: behavioural reference model stepped every clock and compared
// against read data and the level vector at each falling edge.
module test_pcpu_intc;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        timer_in, bcast_in, is_target, global_dis;
    logic [15:1] hard_route, hard_disp;
    logic [15:1] irq_lvl;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    bit [31:0] m_soft;
    bit        m_b15, m_tmr, m_bcp;
    bit [15:0] m_disp, m_irq;

    always #4 clk = ~clk;

    pcpu_intc i_pcpu_intc (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timer_in(timer_in),
        .bcast_in(bcast_in), .is_target(is_target), .global_dis(global_dis),
        .hard_route(hard_route), .hard_disp(hard_disp), .irq_lvl(irq_lvl)
    );

    function automatic bit [31:0] m_read(bit [3:0] a);
        if (a != 4'h0) return 32'h0;
        return m_soft | {16'h0, m_disp} | (32'(m_b15) << 15) | (32'(m_tmr) << 14);
    endfunction

    task automatic model_edge();
        bit clr15 = 1'b0;
        if (!rst_n) begin
            m_soft = 0; m_b15 = 0; m_tmr = 0; m_bcp = 0; m_disp = 0; m_irq = 0;
        end else begin
            if (reg_wr && reg_addr == 4'h4) begin
                m_soft &= ~(reg_wdata & 32'hFFFE_0000);
                clr15 = reg_wdata[15];
            end
            if (reg_wr && reg_addr == 4'h8) m_soft |= reg_wdata & 32'hFFFE_0000;
            if (bcast_in && !m_bcp) m_b15 = 1;
            else if ((!bcast_in && m_bcp) || clr15) m_b15 = 0;
            m_bcp  = bcast_in;
            m_tmr  = timer_in;
            m_disp = is_target ? {hard_disp, 1'b0} : 16'h0;
            m_irq  = {hard_route, 1'b0} | 16'(m_soft >> 16);
            if (!global_dis) m_irq |= (16'(m_b15) << 15) | (16'(m_tmr) << 14);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        n_cmp++;
        if (reg_rdata !== m_read(reg_addr)) begin
            n_bad++;
            $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, reg_addr, reg_rdata, m_read(reg_addr));
        end
        n_cmp++;
        if (irq_lvl !== m_irq[15:1]) begin
            n_bad++;
            $display("FAIL %s irq_lvl actual=%h expected=%h", tag, irq_lvl, m_irq[15:1]);
        end
    endtask

    task automatic wr(bit [3:0] a, bit [31:0] d, string tag);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step(tag);
        reg_wr = 0; reg_addr = 4'h0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        timer_in = 1; bcast_in = 0; is_target = 1; global_dis = 0;
        hard_route = '1; hard_disp = '1;
        repeat (3) step("R1");
        timer_in = 0; hard_route = 0; hard_disp = 0;
        rst_n = 1;
        step("R1");
        // R3: only bits 31..17 can be set
        wr(4'h8, 32'hFFFF_FFFF, "R3");
        step("R6");
        global_dis = 1;
        step("R6");
        // R2: other offsets and unaligned reads give zero
        foreach (reg_addr[i]) begin end
        for (int a = 1; a < 16; a++) begin
            reg_addr = 4'(a);
            step("R2");
        end
        reg_addr = 0;
        // R4: clear selected soft bits
        wr(4'h4, 32'hAAAA_FFFF, "R4");
        wr(4'h4, 32'hFFFF_FFFF, "R4");
        // R7 and R9: timer bit and gating
        timer_in = 1;
        step("R7");
        step("R9");
        global_dis = 0;
        step("R9");
        wr(4'h4, 32'h0000_4000, "R4");
        timer_in = 0;
        step("R7");
        // R8: broadcast latch
        bcast_in = 1;
        step("R8");
        wr(4'h4, 32'h0000_8000, "R8");
        step("R8");
        bcast_in = 0;
        step("R8");
        bcast_in = 1;
        wr(4'h4, 32'h0000_8000, "R8");
        global_dis = 1;
        step("R9");
        bcast_in = 0; global_dis = 0;
        step("R8");
        // R5: writes that miss the command words
        wr(4'h0, 32'hFFFF_FFFF, "R5");
        wr(4'hC, 32'hFFFF_FFFF, "R5");
        wr(4'h9, 32'hFFFF_FFFF, "R5");
        wr(4'h5, 32'hFFFF_FFFF, "R5");
        // R10: display bits follow the target flag
        hard_disp = 15'h5A5A;
        step("R10");
        is_target = 0;
        step("R10");
        wr(4'h4, 32'hFFFF_FFFF, "R10");
        is_target = 1; hard_disp = 15'h7FFF;
        step("R10");
        // R11: routed levels pass through one clock later
        hard_route = 15'h1234;
        step("R11");
        hard_route = 15'h4001; global_dis = 1;
        step("R11");
        hard_route = 0; hard_disp = 0; global_dis = 0;
        step("R11");
        // R11: mixed random traffic
        for (int k = 0; k < 400; k++) begin
            reg_wr     = 1'($urandom);
            reg_addr   = 4'($urandom);
            reg_wdata  = $urandom;
            timer_in   = 1'($urandom);
            bcast_in   = 1'($urandom);
            is_target  = 1'($urandom);
            global_dis = 1'($urandom);
            hard_route = 15'($urandom);
            hard_disp  = 15'($urandom);
            step("R11");
        end
        reg_wr = 0;
        rst_n = 0;
        step("R1");
        rst_n = 1; reg_addr = 0;
        step("R1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule